// File: doc/BRIEF.md
# Rewindable Dual-Clock FIFO

This block is a first-in first-out buffer whose writer and reader run on two unrelated clocks. Words enter on the write clock and leave on the read clock, both at the same time. The data width and the depth are parameters, and the depth must be a power of two. Write and read pointers pass between the two clock domains as Gray code through two-flop synchronisers. Because of this, the status flags can be late, but they never report a wrong condition.

The reader can place a bookmark on its current position and later jump back to it, so that a run of words can be read again. While the bookmark is held, the writer treats the bookmarked word as the oldest stored word, so it cannot overwrite anything that might be replayed. The output timing is chosen while master reset is held. In standard timing a word is shown only after a read request. In fall-through timing the oldest word is presented on the output without a request, and the two status outputs then mean output-ready and input-ready instead of empty and full.

Write and read chip selects gate each port. A partial reset discards the stored data but keeps the chosen timing mode. A master reset clears everything.

Top module: `rewind_fifo`

## Requirements
- R1: Words leave in the order they were written, with their values unchanged, in both timing modes.
- R2: Standard mode (`fwft_sel`=0 at master reset). `empty_or`=1 exactly when no unread word is available, and `full_ir`=1 when DEPTH words are held. A read (`rcs`=1, `ren`=1, not empty) loads the next word into `dout` at the next read-clock edge, and `dout` holds its value at all other times.
- R3: A write attempted while the buffer is full is dropped. The stored contents and their order are unaffected.
- R4: Fall-through mode (`fwft_sel`=1 at master reset). The oldest word appears on `dout` without any read request, and `empty_or` (output-ready) is 1 while `dout` holds a valid word. `full_ir` (input-ready) is 1 while there is space. A read (`rcs`=1, `ren`=1) consumes the shown word.
- R5: While `wcs`=0, no word is written, whatever `wen` does.
- R6: `rcs` is sampled on the read clock. When it is 0, `ren`, `mark` and `retx` have no effect: nothing is consumed and `dout` does not change.
- R7: On the first read-clock edge with `rcs`=1 and `mark`=1, the position of the next unconsumed word is recorded. In standard mode this is the next word to be read; in fall-through mode it is the word on `dout`. A later `retx`=1 with `rcs`=1, while the bookmark is held, returns reading to that position, so the same words are delivered again.
- R8: While the bookmark is held, the full condition counts DEPTH words from the bookmarked position. Dropping it (`mark`=0 with `rcs`=1) releases that space.
- R9: The timing mode follows `fwft_sel` only while `mrst_n`=0. At all other times `fwft_sel` is ignored.
- R10: After master reset the buffer holds no words and `dout`=0. The flags read `empty_or`=1, `full_ir`=0 in standard mode and `empty_or`=0, `full_ir`=1 in fall-through mode.
- R11: Partial reset (`prst_n`=0) discards all words, clears the bookmark and returns the flags to their empty state, but keeps the timing mode.
- R12: Pointers cross between the clock domains one Gray step per cycle. A written word becomes visible to the reader within four read-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; timing mode sampled while low |
| prst_n | input | 1 | Partial reset, active low; keeps timing mode |
| fwft_sel | input | 1 | Timing mode select: 1 fall-through, 0 standard |
| wcs | input | 1 | Write chip select, active high |
| wen | input | 1 | Write request |
| din | input | WIDTH | Write data |
| rcs | input | 1 | Read chip select, sampled on rclk |
| ren | input | 1 | Read request |
| mark | input | 1 | Bookmark hold level |
| retx | input | 1 | Jump back to the bookmark |
| dout | output | WIDTH | Read data register |
| full_ir | output | 1 | Full (standard) or input-ready (fall-through) |
| empty_or | output | 1 | Empty (standard) or output-ready (fall-through) |

## Verification
The assertions assume the following about the inputs:
- Both clocks keep running while either reset is held, because the timing mode is captured by clocked sampling during master reset.
- Resets are released away from the edges of either clock.
- Each domain's controls change only between its own edges.

The bench drives write-side inputs on falling write-clock edges and read-side inputs on falling read-clock edges. It releases resets on a falling write-clock edge, which never coincides with a rising read-clock edge at the chosen periods. Under these conditions the Gray-step and bookmark-boundary properties can rely on single-step pointer movement.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/rewind_fifo_sync.sv
module rewind_fifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/rewind_fifo_mem.sv
module rewind_fifo_mem #(
    parameter  int WIDTH = 8,
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] store_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we_i) store_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = store_q[raddr_i];
endmodule

// File: rtl/rewind_fifo_wr.sv
module rewind_fifo_wr
    import rewind_fifo_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          mrst_n,
    input  logic          fwft_sel,
    input  logic          wcs,
    input  logic          wen,
    input  logic [PW-1:0] bgray_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [PW-1:0] wgray_o,
    output logic          full_ir_o
);
    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] wgray;
    } wr_state_t;

    wr_state_t     st_d, st_q;
    fifo_mode_e    mode_q;
    logic [PW-1:0] bnd_bin;
    logic [PW-1:0] used;
    logic          full;

    // timing mode captured only while master reset is held
    always_ff @(posedge wclk) begin
        if (!mrst_n) mode_q <= fwft_sel ? MODE_FWFT : MODE_STD;
    end

    always_comb begin
        bnd_bin    = PW'(gray_to_bin(32'(bgray_i)));
        used       = st_q.wptr - bnd_bin;
        full       = used[AW];
        we_o       = wcs && wen && !full;
        st_d       = st_q;
        if (we_o) st_d.wptr = st_q.wptr + PW'(1);
        st_d.wgray = PW'(bin_to_gray(32'(st_d.wptr)));
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr_o   = st_q.wptr[AW-1:0];
    assign wgray_o   = st_q.wgray;
    assign full_ir_o = (mode_q == MODE_FWFT) ? !full : full;

    a_r5_wcs_blocks: assert property (@(posedge wclk) disable iff (!rst_n)
        !wcs |=> $stable(st_q.wptr));

    a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        full |=> $stable(st_q.wptr));

    a_r3_occupancy_bound: assert property (@(posedge wclk) disable iff (!rst_n)
        (st_q.wptr - bnd_bin) <= PW'(DEPTH));

    a_r12_wgray_step: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(st_q.wgray ^ $past(st_q.wgray)) <= 1);
endmodule

// File: rtl/rewind_fifo_rd.sv
module rewind_fifo_rd
    import rewind_fifo_pkg::*;
#(
    parameter  int WIDTH = 8,
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             mrst_n,
    input  logic             fwft_sel,
    input  logic             rcs,
    input  logic             ren,
    input  logic             mark_i,
    input  logic             retx_i,
    input  logic [PW-1:0]    wgray_i,
    input  logic [WIDTH-1:0] rdata_i,
    output logic [AW-1:0]    raddr_o,
    output logic [WIDTH-1:0] dout_o,
    output logic             empty_or_o,
    output logic [PW-1:0]    bgray_o
);
    typedef struct packed {
        logic [PW-1:0]    fptr;   // next RAM slot to fetch
        logic [WIDTH-1:0] dout;
        logic             valid;  // fall-through output register holds a word
        logic             marked;
        logic [PW-1:0]    mpos;
        logic [PW-1:0]    bnd;    // oldest protected slot, creeps forward
        logic [PW-1:0]    bgray;
    } rd_state_t;

    rd_state_t     st_d, st_q;
    fifo_mode_e    mode_q;
    logic [PW-1:0] wr_bin;
    logic [PW-1:0] consumed_q, consumed_d, target;
    logic          mem_empty, fwft, take, rewind;

    always_ff @(posedge rclk) begin
        if (!mrst_n) mode_q <= fwft_sel ? MODE_FWFT : MODE_STD;
    end

    always_comb begin
        wr_bin     = PW'(gray_to_bin(32'(wgray_i)));
        mem_empty  = (st_q.fptr == wr_bin);
        fwft       = (mode_q == MODE_FWFT);
        take       = rcs && ren;
        rewind     = rcs && retx_i && st_q.marked;
        consumed_q = st_q.fptr - PW'(fwft && st_q.valid);
        st_d       = st_q;

        if (rewind) begin
            st_d.fptr  = st_q.mpos;
            st_d.valid = 1'b0;
        end else if (fwft) begin
            if (!mem_empty && (!st_q.valid || take)) begin
                st_d.dout  = rdata_i;
                st_d.fptr  = st_q.fptr + PW'(1);
                st_d.valid = 1'b1;
            end else if (take) begin
                st_d.valid = 1'b0;
            end
        end else if (take && !mem_empty) begin
            st_d.dout = rdata_i;
            st_d.fptr = st_q.fptr + PW'(1);
        end

        if (rcs) begin
            if (!mark_i) begin
                st_d.marked = 1'b0;
            end else if (!st_q.marked) begin
                st_d.marked = 1'b1;
                st_d.mpos   = consumed_q;
            end
        end

        consumed_d = st_d.fptr - PW'(fwft && st_d.valid);
        target     = st_d.marked ? st_d.mpos : consumed_d;
        if (st_q.bnd != target) st_d.bnd = st_q.bnd + PW'(1);
        st_d.bgray = PW'(bin_to_gray(32'(st_d.bnd)));
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr_o    = st_q.fptr[AW-1:0];
    assign dout_o     = st_q.dout;
    assign empty_or_o = fwft ? st_q.valid : mem_empty;
    assign bgray_o    = st_q.bgray;

    a_r2_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode_q == MODE_STD && mem_empty && !(rcs && retx_i)) |=> $stable(st_q.fptr));

    a_r6_rcs_blocks: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode_q == MODE_STD && !rcs) |=> ($stable(st_q.fptr) && $stable(st_q.dout)));

    a_r4_shown_word_held: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode_q == MODE_FWFT && st_q.valid && !rcs) |=> (st_q.valid && $stable(st_q.dout)));

    a_r8_bnd_creeps: assert property (@(posedge rclk) disable iff (!rst_n)
        (st_q.bnd - $past(st_q.bnd)) <= PW'(1));

    a_r8_bnd_behind_mark: assert property (@(posedge rclk) disable iff (!rst_n)
        st_q.marked |-> ((st_q.mpos - st_q.bnd) <= PW'(DEPTH)));

    a_r12_bgray_step: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(st_q.bgray ^ $past(st_q.bgray)) <= 1);
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             fwft_sel,
    input  logic             wcs,
    input  logic             wen,
    input  logic [WIDTH-1:0] din,
    input  logic             rcs,
    input  logic             ren,
    input  logic             mark,
    input  logic             retx,
    output logic [WIDTH-1:0] dout,
    output logic             full_ir,
    output logic             empty_or
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic             rst_n;
    logic             we;
    logic [AW-1:0]    waddr, raddr;
    logic [WIDTH-1:0] rdata;
    logic [PW-1:0]    wgray, wgray_rs;
    logic [PW-1:0]    bgray, bgray_ws;

    assign rst_n = mrst_n && prst_n;

    rewind_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .wclk(wclk), .we_i(we), .waddr_i(waddr), .wdata_i(din),
        .raddr_i(raddr), .rdata_o(rdata)
    );

    rewind_fifo_wr #(.DEPTH(DEPTH)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .mrst_n(mrst_n), .fwft_sel(fwft_sel),
        .wcs(wcs), .wen(wen), .bgray_i(bgray_ws), .we_o(we),
        .waddr_o(waddr), .wgray_o(wgray), .full_ir_o(full_ir)
    );

    rewind_fifo_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d_i(wgray), .q_o(wgray_rs)
    );

    rewind_fifo_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d_i(bgray), .q_o(bgray_ws)
    );

    rewind_fifo_rd #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .mrst_n(mrst_n), .fwft_sel(fwft_sel),
        .rcs(rcs), .ren(ren), .mark_i(mark), .retx_i(retx),
        .wgray_i(wgray_rs), .rdata_i(rdata), .raddr_o(raddr),
        .dout_o(dout), .empty_or_o(empty_or), .bgray_o(bgray)
    );
endmodule

// File: tb/rewind_fifo_test.sv
module rewind_fifo_test;
    localparam int WIDTH = 8;
    localparam int DEPTH = 16;

    logic wclk = 1'b0, rclk = 1'b0;
    logic mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
    logic wcs = 1'b1, wen = 1'b0, rcs = 1'b1, ren = 1'b0, mark = 1'b0, retx = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic full_ir, empty_or;

    always #10 wclk = ~wclk;   // 50 MHz write clock
    always #15 rclk = ~rclk;   // unrelated read clock

    rewind_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .fwft_sel(fwft_sel), .wcs(wcs), .wen(wen), .din(din),
        .rcs(rcs), .ren(ren), .mark(mark), .retx(retx),
        .dout(dout), .full_ir(full_ir), .empty_or(empty_or)
    );

    int  checks = 0, fails = 0;
    bit  mode_now = 1'b0;
    bit  done = 1'b0;

    // {fall-through, count, first value, step}
    localparam logic [22:0] VECS [4] = '{
        {1'b0, 6'd5,  8'h01, 8'h01},
        {1'b1, 6'd7,  8'hA0, 8'h03},
        {1'b0, 6'd16, 8'h55, 8'h11},
        {1'b1, 6'd16, 8'hF0, 8'h07}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic master_reset(input bit m);
        @(negedge wclk);
        mrst_n = 1'b0; fwft_sel = m;
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        mrst_n = 1'b1; mode_now = m;
        repeat (2) @(negedge rclk);
    endtask

    task automatic push(input logic [WIDTH-1:0] d);
        @(negedge wclk); din = d; wen = 1'b1;
        @(negedge wclk); wen = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge rclk);
        @(negedge wclk);
        @(negedge rclk);
    endtask

    task automatic pop(output logic [WIDTH-1:0] v);
        @(negedge rclk);
        if (!mode_now) begin
            ren = 1'b1;
            @(negedge rclk); ren = 1'b0;
            v = dout;
        end else begin
            for (int k = 0; k < 20 && !empty_or; k++) @(negedge rclk);
            v = dout;
            ren = 1'b1;
            @(negedge rclk); ren = 1'b0;
        end
    endtask

    task automatic pulse_retx();
        @(negedge rclk); retx = 1'b1;
        @(negedge rclk); retx = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [WIDTH-1:0] v;

        // R10 reset state, standard mode
        master_reset(1'b0);
        @(negedge wclk);
        check("R10 std full_ir", full_ir, 0);
        @(negedge rclk);
        check("R10 std empty_or", empty_or, 1);
        check("R10 dout cleared", dout, 0);

        // R10 reset state, fall-through mode
        master_reset(1'b1);
        @(negedge wclk);
        check("R10 fwft input-ready", full_ir, 1);
        @(negedge rclk);
        check("R10 fwft output-ready", empty_or, 0);

        // R1 R2 R3 R4 vector walk
        for (int t = 0; t < 4; t++) begin
            bit m = VECS[t][22];
            int n = int'(VECS[t][21:16]);
            logic [7:0] b = VECS[t][15:8];
            logic [7:0] s = VECS[t][7:0];
            master_reset(m);
            for (int i = 0; i < n; i++) push(8'(b + i * s));
            settle(8);
            if (!m) begin
                check("R2 not empty after writes", empty_or, 0);
            end else begin
                check("R4 output-ready without read", empty_or, 1);
                check("R4 first word falls through", dout, b);
            end
            if (n == DEPTH) begin
                @(negedge wclk);
                check("R2 R4 full indication", full_ir, m ? 0 : 1);
                push(8'hEE);
                settle(4);
            end
            for (int i = 0; i < n; i++) begin
                pop(v);
                check("R1 order and value", v, 8'(b + i * s));
            end
            settle(8);
            check("R2 R4 empty after draining", empty_or, m ? 0 : 1);
        end

        // R5 write chip select
        master_reset(1'b0);
        @(negedge wclk); wcs = 1'b0; wen = 1'b1; din = 8'h77;
        repeat (4) @(negedge wclk);
        wen = 1'b0; wcs = 1'b1;
        settle(8);
        check("R5 no write while wcs low", empty_or, 1);
        push(8'h31);
        settle(8);
        pop(v);
        check("R5 only selected write stored", v, 8'h31);
        settle(4);
        check("R5 nothing else stored", empty_or, 1);

        // R6 read chip select
        master_reset(1'b0);
        push(8'h41); push(8'h42);
        settle(8);
        @(negedge rclk); rcs = 1'b0; ren = 1'b1; mark = 1'b1; retx = 1'b1;
        repeat (3) @(negedge rclk);
        ren = 1'b0; mark = 1'b0; retx = 1'b0; rcs = 1'b1;
        check("R6 dout unchanged while rcs low", dout, 0);
        check("R6 still not empty", empty_or, 0);
        pop(v);
        check("R6 nothing consumed", v, 8'h41);

        // R12 crossing latency
        master_reset(1'b0);
        push(8'h5A);
        repeat (4) @(negedge rclk);
        check("R12 word visible within four read cycles", empty_or, 0);

        // R7 R8 bookmark in standard mode
        master_reset(1'b0);
        for (int i = 0; i < 4; i++) push(8'(8'h10 + i));
        settle(8);
        @(negedge rclk); mark = 1'b1;
        for (int i = 0; i < 4; i++) begin
            pop(v);
            check("R7 read before rewind", v, 8'(8'h10 + i));
        end
        for (int i = 0; i < 12; i++) push(8'(8'h20 + i));
        settle(6);
        @(negedge wclk);
        check("R8 full counted from bookmark", full_ir, 1);
        push(8'hEE);
        pulse_retx();
        for (int i = 0; i < 16; i++) begin
            pop(v);
            check("R7 replay after rewind", v, (i < 4) ? 8'(8'h10 + i) : 8'(8'h20 + i - 4));
        end
        settle(4);
        check("R3 R7 empty after replay", empty_or, 1);
        @(negedge rclk); mark = 1'b0;
        settle(30);
        @(negedge wclk);
        check("R8 space released after unmark", full_ir, 0);
        push(8'h90);
        settle(8);
        pop(v);
        check("R8 write accepted after release", v, 8'h90);

        // R7 bookmark in fall-through mode
        master_reset(1'b1);
        push(8'hA1); push(8'hA2); push(8'hA3);
        settle(8);
        @(negedge rclk); mark = 1'b1;
        pop(v); check("R7 fwft first read", v, 8'hA1);
        pop(v); check("R7 fwft second read", v, 8'hA2);
        check("R4 next word shown", dout, 8'hA3);
        pulse_retx();
        pop(v); check("R7 fwft replay first", v, 8'hA1);
        pop(v); check("R7 fwft replay second", v, 8'hA2);
        pop(v); check("R7 fwft replay third", v, 8'hA3);
        @(negedge rclk); mark = 1'b0;

        // R9 mode ignored after reset, R11 partial reset keeps mode
        master_reset(1'b1);
        @(negedge wclk); fwft_sel = 1'b0;
        push(8'h61);
        settle(8);
        check("R9 mode held, output-ready", empty_or, 1);
        check("R9 word shown without read", dout, 8'h61);
        @(negedge wclk); prst_n = 1'b0;
        repeat (3) @(negedge rclk);
        @(negedge wclk); prst_n = 1'b1;
        settle(4);
        check("R11 data discarded", empty_or, 0);
        @(negedge wclk);
        check("R11 input-ready after partial reset", full_ir, 1);
        push(8'h62);
        settle(8);
        check("R11 fall-through kept", empty_or, 1);
        check("R11 new word shown", dout, 8'h62);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule